// File: doc/BRIEF.md
# Single-Port Operand Collector Sequencer

This block feeds a multi-cycle functional unit from register storage that has one port, which does either one read or one write per cycle. Time is cut into fixed four-cycle frames. Three slots of each frame fetch the three source operands of one operation, one source per slot. The last slot writes back a result that is waiting. Each access moves a whole row of four registers. The block holds the three rows it has read in capture flops and hands them to the functional unit together in the first cycle of the next frame. In this way a serial stream of reads becomes one parallel operand launch.

The storage holds 16 rows of four 32-bit registers, and every index is a row number. Register `4*row+i` is lane `i` of its row and sits in bits `[32*i+31:32*i]` of a row word. The storage answers a read on the cycle after it is requested. The functional unit returns each result within four cycles of its launch, and returns at most one result per frame. A returned result waits in a holding register until the next write slot. Hazard detection and the arithmetic are outside the block.

Top module: `opc_seq`

## Requirements
- R1: The slot order within a frame is source-1 read, source-2 read, source-3 read, write-back, and then it repeats. `in_ready` is high only in the first slot, so it is high exactly one cycle in four.
- R2: An operation is taken only when `in_valid` and `in_ready` are both high. In that cycle the port reads row `in_src1` (`mem_en`=1, `mem_we`=0). A request raised in any other slot has no effect.
- R3: In the two cycles that follow acceptance, the port reads row `in_src2` and then row `in_src3`, using the indices captured at acceptance.
- R4: Exactly four cycles after acceptance, `fu_go` pulses for one cycle. In that cycle `fu_a`, `fu_b` and `fu_c` carry the rows read for source 1, 2 and 3 together.
- R5: A result that arrives on `fu_res_valid` is written in the write-back slot of the frame in which it arrives (`mem_en`=1, `mem_we`=1, `mem_addr`=destination row, `mem_wdata`=result). This is eleven cycles after the operation was accepted.
- R6: A read slot with no accepted operation makes no storage access.
- R7: A write-back slot with no held result makes no storage access.
- R8: The port makes at most one access per cycle, and a write occurs only in the write-back slot.
- R9: Synchronous reset returns the sequencer to the first slot and discards every pending operation and held result, so no launch or write follows until a new operation is accepted.
- R10: Operations accepted in consecutive frames each land in their own destination row, even when one result arrives in the same cycle as the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | High in the first slot of each frame |
| in_src1 | input | 4 | Row of source 1 |
| in_src2 | input | 4 | Row of source 2 |
| in_src3 | input | 4 | Row of source 3 |
| in_dst | input | 4 | Destination row |
| mem_en | output | 1 | Storage access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 4 | Row index |
| mem_wdata | output | 128 | Row written |
| mem_rdata | input | 128 | Row read, valid one cycle after the request |
| fu_go | output | 1 | Operand launch pulse |
| fu_a | output | 128 | Source-1 row |
| fu_b | output | 128 | Source-2 row |
| fu_c | output | 128 | Source-3 row |
| fu_res_valid | input | 1 | Result strobe from the functional unit |
| fu_res | input | 128 | Result row |

## Verification
Take acceptance as cycle 0. The source-1 read is in cycle 0, the source-2 and source-3 reads are in cycles 1 and 2, the launch is in cycle 4, and with a four-cycle unit the write lands in cycle 11. The bench drives stimulus and samples at the falling edge. It steps one clock at a time from the acceptance edge and compares the port values in exactly those cycles. It also checks that the storage stays idle in the slots between them. For back-to-back runs, the bench replays the operations in its own storage copy and compares the destination rows once all writes are due.

// File: rtl/opc_pkg.sv
package opc_pkg;
  typedef enum logic [1:0] {
    SLOT_RD1 = 2'd0,
    SLOT_RD2 = 2'd1,
    SLOT_RD3 = 2'd2,
    SLOT_WB  = 2'd3
  } slot_e;

  // Frame order: three reads, then the write-back slot, then wrap.
  function automatic slot_e slot_after(slot_e s);
    return slot_e'(2'(s) + 2'd1);
  endfunction

  // Operand k's row arrives one slot after its read request.
  function automatic slot_e capture_slot(int k);
    return slot_e'(2'(k + 1));
  endfunction
endpackage

// File: rtl/opc_slot_ctr.sv
module opc_slot_ctr
  import opc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_e slot,
  output logic  frame_start,
  output logic  wb_slot
);
  always_ff @(posedge clk) begin
    if (rst) slot <= SLOT_RD1;
    else     slot <= slot_after(slot);
  end

  assign frame_start = (slot == SLOT_RD1);
  assign wb_slot     = (slot == SLOT_WB);
endmodule

// File: rtl/opc_capture.sv
module opc_capture
  import opc_pkg::*;
#(
  parameter int GW   = 128,
  parameter int NOPS = 3
) (
  input  logic                     clk,
  input  logic                     busy,
  input  slot_e                    slot,
  input  logic [GW-1:0]            rdata,
  output logic [NOPS-1:0][GW-1:0]  ops
);
  for (genvar k = 0; k < NOPS; k++) begin : g_cap
    always_ff @(posedge clk) begin
      if (busy && slot == capture_slot(k)) ops[k] <= rdata;
    end
  end
endmodule

// File: rtl/opc_wb_hold.sv
module opc_wb_hold #(
  parameter int GW = 128,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_valid,
  input  logic [GW-1:0] res,
  input  logic [RW-1:0] res_dst,
  input  logic          wb_slot,
  output logic          hold_v,
  output logic [GW-1:0] hold_data,
  output logic [RW-1:0] hold_dst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
    end else if (res_valid) begin
      hold_v    <= 1'b1;
      hold_data <= res;
      hold_dst  <= res_dst;
    end else if (wb_slot) begin
      hold_v <= 1'b0;
    end
  end
endmodule

// File: rtl/opc_seq.sv
module opc_seq
  import opc_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int REG_W = 32,
  parameter int GRP   = 4,
  localparam int RW   = $clog2(ROWS),
  localparam int GW   = REG_W * GRP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  input  logic [RW-1:0] in_src3,
  input  logic [RW-1:0] in_dst,
  output logic          mem_en,
  output logic          mem_we,
  output logic [RW-1:0] mem_addr,
  output logic [GW-1:0] mem_wdata,
  input  logic [GW-1:0] mem_rdata,
  output logic          fu_go,
  output logic [GW-1:0] fu_a,
  output logic [GW-1:0] fu_b,
  output logic [GW-1:0] fu_c,
  input  logic          fu_res_valid,
  input  logic [GW-1:0] fu_res
);
  slot_e               slot;
  logic                frame_start, wb_slot, accept, rd_v, go_q, hold_v;
  logic [RW-1:0]       src2_q, src3_q, dst_q, fly_dst, hold_dst;
  logic [GW-1:0]       hold_data;
  logic [2:0][GW-1:0]  ops;

  opc_slot_ctr i_slot (
    .clk(clk), .rst(rst), .slot(slot),
    .frame_start(frame_start), .wb_slot(wb_slot)
  );

  assign in_ready = frame_start;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v <= 1'b0;
      go_q <= 1'b0;
    end else begin
      if (frame_start) rd_v <= accept;
      go_q <= wb_slot && rd_v;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      src2_q <= in_src2;
      src3_q <= in_src3;
      dst_q  <= in_dst;
    end
    if (go_q) fly_dst <= dst_q;
  end

  opc_capture #(.GW(GW), .NOPS(3)) i_cap (
    .clk(clk), .busy(rd_v), .slot(slot), .rdata(mem_rdata), .ops(ops)
  );

  opc_wb_hold #(.GW(GW), .RW(RW)) i_hold (
    .clk(clk), .rst(rst), .res_valid(fu_res_valid), .res(fu_res),
    .res_dst(fly_dst), .wb_slot(wb_slot), .hold_v(hold_v),
    .hold_data(hold_data), .hold_dst(hold_dst)
  );

  always_comb begin
    mem_we   = 1'b0;
    mem_en   = 1'b0;
    mem_addr = in_src1;
    unique case (slot)
      SLOT_RD1: begin mem_en = accept; mem_addr = in_src1; end
      SLOT_RD2: begin mem_en = rd_v;   mem_addr = src2_q;  end
      SLOT_RD3: begin mem_en = rd_v;   mem_addr = src3_q;  end
      SLOT_WB:  begin mem_en = hold_v; mem_we = hold_v; mem_addr = hold_dst; end
      default:  ;
    endcase
  end

  assign mem_wdata = hold_data;
  assign fu_go     = go_q;
  assign fu_a      = ops[0];
  assign fu_b      = ops[1];
  assign fu_c      = ops[2];

  // R1: ready once per frame
  p_ready_gap_r1: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);
  p_ready_period_r1: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> ##4 in_ready);
  // R3: second read follows acceptance with the captured index
  p_src2_follows_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (mem_en && !mem_we && mem_addr == $past(in_src2)));
  // R4: launch four cycles after acceptance
  p_launch_delay_r4: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##4 fu_go);
  // R5: unit must not return a result while one is still waiting
  p_hold_free_r5: assert property (@(posedge clk) disable iff (rst)
    fu_res_valid |-> (!hold_v || wb_slot));
  // R6: idle read slots make no access
  p_idle_reads_r6: assert property (@(posedge clk) disable iff (rst)
    (!rd_v && (slot == SLOT_RD2 || slot == SLOT_RD3)) |-> !mem_en);
  // R7: empty write slot makes no access
  p_empty_wb_r7: assert property (@(posedge clk) disable iff (rst)
    (wb_slot && !hold_v) |-> !mem_en);
  // R8: writes only in the write-back slot
  p_write_slot_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_en && wb_slot && !in_ready));
  // R9: after reset the frame restarts with nothing pending
  p_reset_clean_r9: assert property (@(posedge clk)
    $past(rst) |-> (in_ready && !fu_go && !hold_v));
endmodule

// File: tb/test_opc_seq.sv
module test_opc_seq;
  localparam int CLK_P = 10;
  localparam int GW = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [3:0] in_src1 = '0, in_src2 = '0, in_src3 = '0, in_dst = '0;
  logic in_ready, mem_en, mem_we, fu_go;
  logic [3:0] mem_addr;
  logic [GW-1:0] mem_wdata, fu_a, fu_b, fu_c;
  logic [GW-1:0] mem_rdata = '0;
  logic fu_res_valid;
  logic [GW-1:0] fu_res;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  opc_seq i_opc_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_src1(in_src1), .in_src2(in_src2), .in_src3(in_src3), .in_dst(in_dst),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fu_go(fu_go),
    .fu_a(fu_a), .fu_b(fu_b), .fu_c(fu_c),
    .fu_res_valid(fu_res_valid), .fu_res(fu_res)
  );

  function automatic logic [GW-1:0] row_init(int r);
    logic [GW-1:0] v;
    for (int i = 0; i < 4; i++)
      v[32*i +: 32] = 32'(r) * 32'h0101_0101 + 32'(i) * 32'h0010_0007 + 32'h5a5a_0000;
    return v;
  endfunction

  function automatic logic [GW-1:0] unit_fn(logic [GW-1:0] a, b, c);
    logic [GW-1:0] v;
    for (int i = 0; i < 4; i++)
      v[32*i +: 32] = (a[32*i +: 32] + b[32*i +: 32]) ^ c[32*i +: 32];
    return v;
  endfunction

  // storage model: one access per cycle, read data next cycle
  logic [GW-1:0] smem [16];
  always @(posedge clk) begin
    if (mem_en && mem_we) smem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= smem[mem_addr];
  end

  // functional unit model: four-cycle latency
  logic [3:0] dv = '0;
  logic [GW-1:0] dd [4];
  always @(posedge clk) begin
    dv <= rst ? 4'b0 : {dv[2:0], fu_go};
    dd[0] <= unit_fn(fu_a, fu_b, fu_c);
    dd[1] <= dd[0];
    dd[2] <= dd[1];
    dd[3] <= dd[2];
  end
  assign fu_res_valid = dv[3];
  assign fu_res = dd[3];

  task automatic chk(bit ok, string req, logic [GW-1:0] act, logic [GW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // {src1, src2, src3, dst}; sources never written, so results are independent
  localparam logic [15:0] VEC [6] = '{
    16'h012_C, 16'h345_D, 16'h678_E, 16'h9AB_F, 16'hB05_C, 16'h2A7_D
  };

  initial begin
    #(CLK_P * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [GW-1:0] ref_mem [16];
    for (int r = 0; r < 16; r++) begin
      smem[r] = row_init(r);
      ref_mem[r] = row_init(r);
    end
    repeat (3) step();
    rst = 1'b0;
    #1;
    // R9: reset state
    chk(in_ready && !fu_go && !mem_en, "R9 reset state", {in_ready, fu_go, mem_en}, 3'b100);

    // R1, R6, R7: idle frame
    for (int k = 0; k < 8; k++) begin
      chk(in_ready == (k % 4 == 0), "R1 ready pattern", in_ready, (k % 4 == 0));
      chk(!mem_en, "R6/R7 idle access", mem_en, 0);
      step();
    end

    // directed single operation, acceptance = cycle 0
    in_valid = 1'b1; in_src1 = 4'd1; in_src2 = 4'd2; in_src3 = 4'd3; in_dst = 4'd13;
    #1;
    chk(mem_en && !mem_we && mem_addr == 4'd1, "R2 src1 read", {mem_en, mem_we, mem_addr}, {2'b10, 4'd1});
    step(); // cycle 1: stray request held high, must be ignored
    in_src1 = 4'd9; in_src2 = 4'd9; in_src3 = 4'd9; in_dst = 4'd14;
    #1;
    chk(!in_ready, "R1 busy slot", in_ready, 0);
    chk(mem_en && !mem_we && mem_addr == 4'd2, "R3 src2 read", {mem_en, mem_we, mem_addr}, {2'b10, 4'd2});
    step(); // cycle 2
    chk(mem_en && !mem_we && mem_addr == 4'd3, "R3 src3 read", {mem_en, mem_we, mem_addr}, {2'b10, 4'd3});
    step(); // cycle 3
    chk(!mem_en, "R7 empty write slot", mem_en, 0);
    in_valid = 1'b0;
    step(); // cycle 4
    chk(fu_go, "R4 launch pulse", fu_go, 1);
    chk(fu_a == row_init(1), "R4 operand a", fu_a, row_init(1));
    chk(fu_b == row_init(2), "R4 operand b", fu_b, row_init(2));
    chk(fu_c == row_init(3), "R4 operand c", fu_c, row_init(3));
    chk(!mem_en, "R2 no accept while idle", mem_en, 0);
    for (int k = 5; k < 8; k++) begin
      step();
      chk(!mem_en && !fu_go, "R6 idle after launch", {mem_en, fu_go}, 2'b00);
    end
    step(); // cycle 8
    chk(!fu_go, "R2 stray request ignored", fu_go, 0);
    step(); step(); step(); // cycle 11
    chk(mem_en && mem_we && mem_addr == 4'd13, "R5 write port", {mem_en, mem_we, mem_addr}, {2'b11, 4'd13});
    chk(mem_wdata == unit_fn(row_init(1), row_init(2), row_init(3)), "R5 write data",
        mem_wdata, unit_fn(row_init(1), row_init(2), row_init(3)));
    step();
    chk(smem[14] == row_init(14), "R2 stray dst untouched", smem[14], row_init(14));
    ref_mem[13] = unit_fn(row_init(1), row_init(2), row_init(3));

    // reset in the middle of an operation
    while (!in_ready) step();
    in_valid = 1'b1; in_src1 = 4'd4; in_src2 = 4'd5; in_src3 = 4'd6; in_dst = 4'd15;
    step();
    in_valid = 1'b0;
    step();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    #1;
    chk(in_ready, "R9 restart slot", in_ready, 1);
    for (int k = 0; k < 12; k++) begin
      chk(!mem_en && !fu_go, "R9 nothing pending", {mem_en, fu_go}, 2'b00);
      step();
    end
    chk(smem[15] == row_init(15), "R9 no write after reset", smem[15], row_init(15));

    // back-to-back operations from the table
    foreach (VEC[v]) begin
      while (!in_ready) step();
      in_valid = 1'b1;
      {in_src1, in_src2, in_src3, in_dst} = VEC[v];
      #1;
      chk(mem_en && mem_addr == VEC[v][15:12], "R2 table src1 read", mem_addr, VEC[v][15:12]);
      ref_mem[VEC[v][3:0]] = unit_fn(row_init(int'(VEC[v][15:12])),
                                     row_init(int'(VEC[v][11:8])),
                                     row_init(int'(VEC[v][7:4])));
      step();
      in_valid = 1'b0;
    end
    repeat (16) step();
    for (int r = 12; r < 16; r++)
      chk(smem[r] == ref_mem[r], "R10 back-to-back results", smem[r], ref_mem[r]);
    finish_run();
  end
endmodule